// File: doc/BRIEF.md
# Single-Precision to Signed Integer Converter

This block turns a 32-bit IEEE-754 single-precision word into a 32-bit two's-complement integer, as a store-to-integer operation would. The caller presents the float word and a 2-bit rounding-direction code, then pulses `start` for one cycle. Two rising edges later the block pulses `done` for one cycle. At that point `intOut` holds the converted value. `invalid` reports that the source had no integer meaning. `inexact` reports that rounding threw away nonzero bits.

The significand is aligned to the integer's unit position. One guard bit and one sticky bit are kept from the bits that fall off. The chosen direction then decides whether the magnitude goes up by one. The sign is applied last, by negating the rounded magnitude. Results outside the signed range, infinities and NaNs all produce the integer indefinite code 80000000h.

Top module: `f2i_conv`

## Requirements
- R1: Rounding code 2'b11 truncates toward zero (5.64 gives 5, -2.5 gives -2).
- R2: Rounding code 2'b00 rounds to nearest, with ties going to the even integer (5.64 gives 6, 2.5 gives 2, 3.5 gives 4, 0.5 gives 0, 0.75 gives 1).
- R3: Rounding code 2'b01 rounds toward minus infinity (-2.5 gives -3, -0.5 gives -1, 5.64 gives 5).
- R4: Rounding code 2'b10 rounds toward plus infinity (5.64 gives 6, 0.25 gives 1, -2.5 gives -2).
- R5: A negative source yields the two's complement of the magnitude that was rounded under the selected direction. A positive source never yields an integer with bit 31 set.
- R6: `inexact` is 1 exactly when nonzero bits were discarded during alignment, and 0 for exactly representable values such as 1.0.
- R7: A source with an all-ones exponent field (infinity or NaN) yields `invalid`=1, `intOut`=80000000h and `inexact`=0.
- R8: A rounded magnitude that does not fit the signed 32-bit range yields `invalid`=1, `intOut`=80000000h and `inexact`=0. The value -2^31 (CF000000h) converts exactly with `invalid`=0.
- R9: Signed zero converts to 0 exactly. A nonzero denormal gives 0 with `inexact`=1 under nearest and truncate. Under a directed code it gives +1 (positive, code 2'b10) or -1 (negative, code 2'b01), and 0 when the sign opposes the direction.
- R10: `done` rises on the second rising clock edge after the edge that samples `start`, stays high for one cycle, and the results hold their value until the next `done`. After reset `done`, `intOut`, `invalid` and `inexact` are all 0.
- R11: Sources of magnitude 2^23 or more that fit the range convert exactly by shifting left (4BC00000h gives 01800000h, 4EFFFFFFh gives 7FFFFF80h).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; samples `fltIn` and `rndMode` |
| fltIn | input | 32 | Single-precision source word |
| rndMode | input | 2 | Rounding direction: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| intOut | output | 32 | Signed integer result |
| done | output | 1 | One-cycle pulse marking a new result |
| invalid | output | 1 | Source was NaN, infinity or out of range |
| inexact | output | 1 | Rounding discarded nonzero bits |

## Verification
The operands are captured on the edge that samples `start`. The result registers load on the following edge, so `intOut`, `invalid`, `inexact` and `done` are all due two rising edges after `start` is sampled. Each request in the bench raises `start` on a falling edge and lowers it at the next falling edge. The outputs are then read at the falling edge after the second rising edge, halfway between the clock edges. The directed tests also read the outputs one cycle later, to confirm that `done` has dropped and the result has held. They also issue two back-to-back requests and read the results one cycle apart.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int INT_W  = 32;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands
    logic commit;  // register converted result
  } ctl_t;
endpackage

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output ctl_t ctl,
  output logic done
);
  logic commitQ;
  logic doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      commitQ <= start;
      doneQ   <= commitQ;
    end
  end

  always_comb begin
    ctl.load   = start;
    ctl.commit = commitQ;
  end

  assign done = doneQ;
endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W-1:0]  expIn,
  input  logic [FRAC_W-1:0] fracIn,
  output logic [INT_W:0]    magRaw,
  output logic              guard,
  output logic              sticky,
  output logic              special,
  output logic              tooBig
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int WIN_W = 2 * SIG_W + 1;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] UNIT_E = EXP_W'(BIAS + FRAC_W);
  localparam logic [EXP_W-1:0] TOP_E  = EXP_W'(BIAS + INT_W - 1);
  localparam logic [EXP_W-1:0] SIG_LIM = EXP_W'(SIG_W);

  logic [SIG_W-1:0] sig;
  logic [EXP_W-1:0] lshAmt;
  logic [EXP_W-1:0] rshAmt;
  logic [WIN_W-1:0] win;

  // hidden bit present only for normal encodings
  assign sig    = {|expIn, fracIn};
  assign lshAmt = expIn - UNIT_E;
  assign rshAmt = UNIT_E - expIn;
  assign win    = {sig, {(SIG_W + 1){1'b0}}} >> rshAmt;

  always_comb begin
    magRaw  = '0;
    guard   = 1'b0;
    sticky  = 1'b0;
    special = 1'b0;
    tooBig  = 1'b0;
    if (expIn == '1) begin
      special = 1'b1;
    end else if (expIn > TOP_E) begin
      tooBig = 1'b1;
    end else if (expIn >= UNIT_E) begin
      magRaw = {{(INT_W + 1 - SIG_W){1'b0}}, sig} << lshAmt;
    end else if (rshAmt > SIG_LIM) begin
      // whole significand below the guard position
      sticky = |sig;
    end else begin
      magRaw = {{(INT_W + 1 - SIG_W){1'b0}}, win[WIN_W-1 -: SIG_W]};
      guard  = win[SIG_W];
      sticky = |win[SIG_W-1:0];
    end
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             signIn,
  input  rnd_e             mode,
  input  logic [INT_W:0]   magRaw,
  input  logic             guard,
  input  logic             sticky,
  input  logic             special,
  input  logic             tooBig,
  output logic [INT_W-1:0] result,
  output logic             invalid,
  output logic             inexact
);
  localparam logic [INT_W:0] POS_LIM = {2'b00, {(INT_W - 1){1'b1}}};
  localparam logic [INT_W:0] NEG_LIM = {2'b01, {(INT_W - 1){1'b0}}};
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W - 1){1'b0}}};

  logic           lost;
  logic           inc;
  logic [INT_W:0] magR;
  logic           ovf;
  logic           bad;

  assign lost = guard | sticky;

  always_comb begin
    unique case (mode)
      RND_NEAR: inc = guard & (sticky | magRaw[0]);
      RND_DOWN: inc = lost & signIn;
      RND_UP:   inc = lost & ~signIn;
      default:  inc = 1'b0;
    endcase
  end

  assign magR = magRaw + {{INT_W{1'b0}}, inc};
  assign ovf  = signIn ? (magR > NEG_LIM) : (magR > POS_LIM);
  assign bad  = special | tooBig | ovf;

  always_comb begin
    if (bad)          result = INDEF;
    else if (signIn)  result = -magR[INT_W-1:0];
    else              result = magR[INT_W-1:0];
    invalid = bad;
    inexact = ~bad & lost;
  end
endmodule

// File: rtl/f2i_dpath.sv
module f2i_dpath
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_t                    ctl,
  input  logic [EXP_W+FRAC_W:0]   fltIn,
  input  logic [1:0]              rndMode,
  output logic [INT_W-1:0]        intOut,
  output logic                    invalid,
  output logic                    inexact
);
  localparam int FLT_W = EXP_W + FRAC_W + 1;

  logic [FLT_W-1:0] fltQ;
  rnd_e             modeQ;
  logic [INT_W:0]   magRaw;
  logic             guard, sticky, special, tooBig;
  logic [INT_W-1:0] resNext;
  logic             invNext, inxNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fltQ  <= '0;
      modeQ <= RND_NEAR;
    end else if (ctl.load) begin
      fltQ  <= fltIn;
      modeQ <= rnd_e'(rndMode);
    end
  end

  f2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .expIn  (fltQ[FLT_W-2 -: EXP_W]),
    .fracIn (fltQ[FRAC_W-1:0]),
    .magRaw (magRaw),
    .guard  (guard),
    .sticky (sticky),
    .special(special),
    .tooBig (tooBig)
  );

  f2i_round #(.INT_W(INT_W)) u_round (
    .signIn (fltQ[FLT_W-1]),
    .mode   (modeQ),
    .magRaw (magRaw),
    .guard  (guard),
    .sticky (sticky),
    .special(special),
    .tooBig (tooBig),
    .result (resNext),
    .invalid(invNext),
    .inexact(inxNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intOut  <= '0;
      invalid <= 1'b0;
      inexact <= 1'b0;
    end else if (ctl.commit) begin
      intOut  <= resNext;
      invalid <= invNext;
      inexact <= inxNext;
    end
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int EXP_W  = f2i_pkg::EXP_W,
  parameter int FRAC_W = f2i_pkg::FRAC_W,
  parameter int INT_W  = f2i_pkg::INT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] fltIn,
  input  logic [1:0]            rndMode,
  output logic [INT_W-1:0]      intOut,
  output logic                  done,
  output logic                  invalid,
  output logic                  inexact
);
  ctl_t ctl;

  f2i_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctl  (ctl),
    .done (done)
  );

  f2i_dpath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .fltIn  (fltIn),
    .rndMode(rndMode),
    .intOut (intOut),
    .invalid(invalid),
    .inexact(inexact)
  );
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int EXP_W = 8,
  parameter int INT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [EXP_W:0]   fltTop,
  input logic [INT_W-1:0] intOut,
  input logic             done,
  input logic             invalid,
  input logic             inexact
);
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W - 1){1'b0}}};

  // R10: result pulse two edges after a sampled request
  a_r10_done_latency: assert property (@(posedge clk) disable iff (!rstN)
    start |-> ##2 done);

  // R10: no pulse without a request
  a_r10_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start, 2));

  // R10: results only move together with done
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(intOut) && $stable(invalid) && $stable(inexact));

  // R7: all-ones exponent is rejected
  a_r7_special: assert property (@(posedge clk) disable iff (!rstN)
    done && ($past(fltTop[EXP_W-1:0], 2) == '1) |-> invalid);

  // R8: a rejected source always carries the indefinite code
  a_r8_indef_code: assert property (@(posedge clk) disable iff (!rstN)
    done && invalid |-> (intOut == INDEF) && !inexact);

  // R5: positive sources never produce a negative integer
  a_r5_sign: assert property (@(posedge clk) disable iff (!rstN)
    done && !invalid && !$past(fltTop[EXP_W], 2) |-> !intOut[INT_W-1]);
endmodule

bind f2i_conv f2i_conv_chk #(.EXP_W(EXP_W), .INT_W(INT_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .fltTop (fltIn[EXP_W+FRAC_W:FRAC_W]),
  .intOut (intOut),
  .done   (done),
  .invalid(invalid),
  .inexact(inexact)
);

// File: tb/test_f2i_conv.sv
`timescale 1ns/1ps
module test_f2i_conv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] fltIn = '0;
  logic [1:0]  rndMode = '0;
  logic [31:0] intOut;
  logic        done, invalid, inexact;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  f2i_conv i_f2i_conv (
    .clk(clk), .rstN(rstN), .start(start), .fltIn(fltIn), .rndMode(rndMode),
    .intOut(intOut), .done(done), .invalid(invalid), .inexact(inexact)
  );

  typedef struct packed {
    logic [31:0] f;
    logic [1:0]  m;
    logic [31:0] q;
    logic        inv;
    logic        inx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{32'h40B47AE1, 2'b00, 32'h00000006, 1'b0, 1'b1, 4'd2},  // R2 5.64
    '{32'h40B47AE1, 2'b11, 32'h00000005, 1'b0, 1'b1, 4'd1},  // R1
    '{32'h40B47AE1, 2'b01, 32'h00000005, 1'b0, 1'b1, 4'd3},  // R3
    '{32'h40B47AE1, 2'b10, 32'h00000006, 1'b0, 1'b1, 4'd4},  // R4
    '{32'h40200000, 2'b00, 32'h00000002, 1'b0, 1'b1, 4'd2},  // R2 tie 2.5
    '{32'h40600000, 2'b00, 32'h00000004, 1'b0, 1'b1, 4'd2},  // R2 tie 3.5
    '{32'h3F400000, 2'b00, 32'h00000001, 1'b0, 1'b1, 4'd2},  // R2 0.75
    '{32'h3F000000, 2'b00, 32'h00000000, 1'b0, 1'b1, 4'd2},  // R2 0.5
    '{32'hC0200000, 2'b00, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd5},  // R5 -2.5
    '{32'hC0200000, 2'b01, 32'hFFFFFFFD, 1'b0, 1'b1, 4'd3},  // R3
    '{32'hC0200000, 2'b10, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd4},  // R4
    '{32'hC0200000, 2'b11, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd1},  // R1
    '{32'hBF000000, 2'b01, 32'hFFFFFFFF, 1'b0, 1'b1, 4'd3},  // R3 -0.5
    '{32'h3E800000, 2'b10, 32'h00000001, 1'b0, 1'b1, 4'd4},  // R4 0.25
    '{32'hC0B47AE1, 2'b11, 32'hFFFFFFFB, 1'b0, 1'b1, 4'd5},  // R5 -5.64
    '{32'h3F800000, 2'b10, 32'h00000001, 1'b0, 1'b0, 4'd6},  // R6 exact 1.0
    '{32'h3F800000, 2'b01, 32'h00000001, 1'b0, 1'b0, 4'd6},  // R6
    '{32'h4BC00000, 2'b00, 32'h01800000, 1'b0, 1'b0, 4'd11}, // R11
    '{32'h4EFFFFFF, 2'b10, 32'h7FFFFF80, 1'b0, 1'b0, 4'd11}, // R11
    '{32'hCF000000, 2'b00, 32'h80000000, 1'b0, 1'b0, 4'd8},  // R8 -2^31
    '{32'h4F000000, 2'b00, 32'h80000000, 1'b1, 1'b0, 4'd8},  // R8 2^31
    '{32'h7F800000, 2'b00, 32'h80000000, 1'b1, 1'b0, 4'd7},  // R7 +inf
    '{32'hFF800000, 2'b11, 32'h80000000, 1'b1, 1'b0, 4'd7},  // R7 -inf
    '{32'h7FC00000, 2'b10, 32'h80000000, 1'b1, 1'b0, 4'd7},  // R7 NaN
    '{32'h00000000, 2'b10, 32'h00000000, 1'b0, 1'b0, 4'd9},  // R9 +0
    '{32'h80000000, 2'b01, 32'h00000000, 1'b0, 1'b0, 4'd9},  // R9 -0
    '{32'h00000001, 2'b10, 32'h00000001, 1'b0, 1'b1, 4'd9},  // R9 denormal up
    '{32'h00000001, 2'b00, 32'h00000000, 1'b0, 1'b1, 4'd9},  // R9
    '{32'h80000001, 2'b01, 32'hFFFFFFFF, 1'b0, 1'b1, 4'd9},  // R9
    '{32'h80000001, 2'b10, 32'h00000000, 1'b0, 1'b1, 4'd9}   // R9
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic request(input logic [31:0] f, input logic [1:0] m);
    @(negedge clk);
    fltIn   = f;
    rndMode = m;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    #1_000_000;
    nBad++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(10, "reset done",    {31'b0, done},    32'd0);
    check(10, "reset intOut",  intOut,           32'd0);
    check(10, "reset invalid", {31'b0, invalid}, 32'd0);
    check(10, "reset inexact", {31'b0, inexact}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      request(VECS[i].f, VECS[i].m);
      check(int'(VECS[i].req), "value",   intOut,                   VECS[i].q);
      check(int'(VECS[i].req), "invalid", {31'b0, invalid},         {31'b0, VECS[i].inv});
      check(int'(VECS[i].req), "inexact", {31'b0, inexact},         {31'b0, VECS[i].inx});
      check(10,                "done",    {31'b0, done},            32'd1);
    end

    // R10: pulse is one cycle wide and result holds while inputs move
    request(32'h40B47AE1, 2'b00);
    fltIn   = 32'h7F800000;
    rndMode = 2'b11;
    @(negedge clk);
    check(10, "done width",  {31'b0, done},    32'd0);
    check(10, "held value",  intOut,           32'd6);
    check(10, "held flag",   {31'b0, invalid}, 32'd0);
    repeat (3) @(negedge clk);
    check(10, "still held",  intOut,           32'd6);

    // R10: back-to-back requests
    @(negedge clk);
    fltIn = 32'h40600000; rndMode = 2'b00; start = 1'b1;
    @(negedge clk);
    fltIn = 32'hC0200000; rndMode = 2'b01;
    @(negedge clk);
    start = 1'b0;
    check(10, "b2b first",  intOut,        32'd4);
    check(10, "b2b done1",  {31'b0, done}, 32'd1);
    @(negedge clk);
    check(3,  "b2b second", intOut,        32'hFFFFFFFD);
    check(10, "b2b done2",  {31'b0, done}, 32'd1);
    @(negedge clk);
    check(10, "b2b idle",   {31'b0, done}, 32'd0);

    summary();
    $finish;
  end
endmodule